// File: doc/BRIEF.md
# Programmable Clock-Enable Divider Slice

This block derives a slow enable from one of several source enables. All logic runs on one system clock. Each source "clock" is a one-cycle strobe on that clock. The block counts strobes from the chosen source and emits a one-cycle pulse each time a programmed number of strobes has been seen. The result is a divided pulse train that other logic uses as a clock enable.

A single 32-bit control word configures the slice. Software writes it through a simple write strobe with data, and reads it back on a combinational read bus. The word holds three things:

- the divide ratio, stored as ratio minus one;
- a stop bit that silences the output;
- a source-select field. Its position depends on how many sources the slice is built with: one, four or eight.

A change of ratio or source is held back until the current output period ends, so no short period is ever produced.

Top module: `clkdiv_slice`

## Requirements
- R1: After reset the control word reads with bit 8 (stop) set, bits [5:0] equal to 63 and the select field equal to 0. `running` is low and no pulse is produced.
- R2: With bits [5:0] holding F and the slice running, `out_pulse` is high for exactly one cycle, in the same cycle as every (F+1)-th strobe of the selected source. F=0 pulses on every strobe and F=63 on every 64th.
- R3: While bit 8 reads as 1, `out_pulse` stays low whatever the strobes do. `running` equals the inverse of bit 8 in every cycle.
- R4: A write with bit 8 set and bits [5:0] equal to 0 stores 63 in bits [5:0]. Any other write stores bits [5:0] exactly as written.
- R5: A write that clears bit 8 restarts counting from zero at the ratio in that write. The first pulse comes on the (F+1)-th selected strobe after the write, whatever partial count existed before the stop.
- R6: A ratio written while running leaves the current period at the old ratio and applies from the next period. If the write lands in the same cycle as the strobe that completes a period, that strobe still pulses, and the following period also uses the old ratio.
- R7: The select value k picks `src_tick[k]`. With eight sources the field is bits [14:12]; with four sources it is bits [7:6]. Strobes on other inputs are ignored. A select change while running applies from the next period boundary.
- R8: With one source there are no select bits: the field reads as zero and `src_tick[0]` is always used.
- R9: Control bits outside [5:0], bit 8 and the select field read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | NUM_SRC | One-cycle source strobes, one per source |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Current control word |
| out_pulse | output | 1 | Divided one-cycle pulse |
| running | output | 1 | High while the stop bit is clear |

## Verification
A control write and the strobe that closes an output period can arrive in the same cycle. The bench forces this with a write of a new ratio driven together with the completing strobe. The expected outcome: that cycle still pulses, the next period keeps the old ratio, and only the period after it uses the new one. The scoreboard predicts the exact cycle of every pulse, so any early adoption of the new ratio shows up as a cycle mismatch or as an unexpected pulse.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int CTRL_W   = 32;
  localparam int RATIO_W  = 6;
  localparam int STOP_POS = 8;

  // number of select bits for a given source count
  function automatic int sel_bits(input int n_src);
    return (n_src <= 1) ? 0 : $clog2(n_src);
  endfunction

  // lowest bit of the select field
  function automatic int sel_lsb(input int n_src);
    return (n_src > 4) ? 12 : 6;
  endfunction

  // ratio field as stored: a stopped word never keeps a zero ratio
  function automatic logic [RATIO_W-1:0] stored_ratio(input logic stop,
                                                      input logic [RATIO_W-1:0] f);
    return (stop && f == '0) ? '1 : f;
  endfunction

  // strobe counter step: wraps to zero at the period limit
  function automatic logic [RATIO_W-1:0] count_step(input logic [RATIO_W-1:0] cnt,
                                                    input logic [RATIO_W-1:0] lim);
    return (cnt == lim) ? '0 : cnt + 1'b1;
  endfunction

endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg #(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 3
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic [clkdiv_pkg::CTRL_W-1:0]         wr_data,
  output logic                                  stop_o,
  output logic [clkdiv_pkg::RATIO_W-1:0]        ratio_o,
  output logic [SEL_W-1:0]                      sel_o,
  output logic [clkdiv_pkg::CTRL_W-1:0]         rd_data
);
  import clkdiv_pkg::*;

  localparam int SEL_BITS = sel_bits(NUM_SRC);
  localparam int SEL_LSB  = sel_lsb(NUM_SRC);

  logic                 stop_q;
  logic [RATIO_W-1:0]   ratio_q;
  logic [SEL_W-1:0]     sel_q;
  logic [SEL_W-1:0]     wr_sel;
  logic [CTRL_W-1:0]    sel_field;
  logic                 unused_wr;

  assign unused_wr = ^wr_data;

  generate
    if (SEL_BITS > 0) begin : g_sel
      assign wr_sel    = wr_data[SEL_LSB +: SEL_BITS];
      assign sel_field = CTRL_W'(sel_q) << SEL_LSB;
    end else begin : g_nosel
      assign wr_sel    = '0;
      assign sel_field = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_q  <= 1'b1;
      ratio_q <= '1;
      sel_q   <= '0;
    end else if (wr_en) begin
      stop_q  <= wr_data[STOP_POS];
      ratio_q <= stored_ratio(wr_data[STOP_POS], wr_data[RATIO_W-1:0]);
      sel_q   <= wr_sel;
    end
  end

  always_comb begin
    rd_data                 = sel_field;
    rd_data[RATIO_W-1:0]    = ratio_q;
    rd_data[STOP_POS]       = stop_q;
  end

  assign stop_o  = stop_q;
  assign ratio_o = ratio_q;
  assign sel_o   = sel_q;

  AST_STOP_RATIO_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> (ratio_q != '0));  // R4

endmodule

// File: rtl/clkdiv_src_mux.sv
module clkdiv_src_mux #(
  parameter int NUM_SRC = 8,
  parameter int SEL_W   = 3
) (
  input  logic [NUM_SRC-1:0] ticks,
  input  logic [SEL_W-1:0]   sel,
  output logic               tick_sel
);
  generate
    if (NUM_SRC == 1) begin : g_single
      logic unused_sel;
      assign unused_sel = ^sel;
      assign tick_sel   = ticks[0];
    end else begin : g_multi
      always_comb begin
        tick_sel = 1'b0;
        for (int i = 0; i < NUM_SRC; i++)
          if (int'(sel) == i) tick_sel = ticks[i];
      end
    end
  endgenerate
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int SEL_W = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               stop,
  input  logic [clkdiv_pkg::RATIO_W-1:0]     cfg_ratio,
  input  logic [SEL_W-1:0]                   cfg_sel,
  input  logic                               tick,
  output logic [SEL_W-1:0]                   eff_sel,
  output logic                               pulse
);
  import clkdiv_pkg::*;

  logic [RATIO_W-1:0] cnt_q, act_ratio_q, eff_ratio;
  logic [SEL_W-1:0]   act_sel_q;
  logic               idle_q;
  logic               period_end;
  logic               load_cfg;

  // while idle (first running cycle) the programmed values are used directly
  assign eff_ratio  = idle_q ? cfg_ratio : act_ratio_q;
  assign eff_sel    = idle_q ? cfg_sel   : act_sel_q;
  assign period_end = !stop && tick && (cnt_q == eff_ratio);
  assign load_cfg   = !stop && (idle_q || period_end);
  assign pulse      = period_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q      <= 1'b1;
      cnt_q       <= '0;
      act_ratio_q <= '1;
      act_sel_q   <= '0;
    end else if (stop) begin
      idle_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      idle_q <= 1'b0;
      if (load_cfg) begin
        act_ratio_q <= cfg_ratio;
        act_sel_q   <= cfg_sel;
      end
      if (tick) cnt_q <= count_step(cnt_q, eff_ratio);
    end
  end

  AST_COUNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !stop |-> (cnt_q <= eff_ratio));  // R2

  AST_RESTART_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop) |-> (cnt_q == '0));  // R5

  AST_RATIO_HELD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !idle_q && !(tick && cnt_q == act_ratio_q)) |=> $stable(act_ratio_q));  // R6

  AST_SEL_HELD_MID_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop && !idle_q && !(tick && cnt_q == act_ratio_q)) |=> $stable(act_sel_q));  // R7

endmodule

// File: rtl/clkdiv_slice.sv
module clkdiv_slice #(
  parameter int NUM_SRC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_tick,
  input  logic                wr_en,
  input  logic [31:0]         wr_data,
  output logic [31:0]         rd_data,
  output logic                out_pulse,
  output logic                running
);
  import clkdiv_pkg::*;

  localparam int SEL_BITS = sel_bits(NUM_SRC);
  localparam int SEL_W    = (SEL_BITS > 0) ? SEL_BITS : 1;

  logic               stop_w;
  logic [RATIO_W-1:0] ratio_w;
  logic [SEL_W-1:0]   sel_w;
  logic [SEL_W-1:0]   eff_sel_w;
  logic               tick_w;

  clkdiv_ctrl_reg #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .stop_o(stop_w), .ratio_o(ratio_w), .sel_o(sel_w), .rd_data(rd_data)
  );

  clkdiv_src_mux #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_mux (
    .ticks(src_tick), .sel(eff_sel_w), .tick_sel(tick_w)
  );

  clkdiv_counter #(.SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .stop(stop_w), .cfg_ratio(ratio_w),
    .cfg_sel(sel_w), .tick(tick_w), .eff_sel(eff_sel_w), .pulse(out_pulse)
  );

  assign running = !stop_w;

endmodule

// File: tb/clkdiv_slice_bench.sv
module clkdiv_slice_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src_tick = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        out_pulse, running;

  logic        wr_en4 = 1'b0, wr_en1 = 1'b0;
  logic [3:0]  tick4 = '0;
  logic [0:0]  tick1 = '0;
  logic [31:0] rd4, rd1;
  logic        out4, run4, out1, run1;

  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R1";

  int    exp_cyc[$];
  string exp_tag[$];

  // independent model state (requirement level)
  bit       m_stop = 1;
  bit [5:0] m_ratio = 6'd63, a_ratio = 6'd63;
  bit [2:0] m_sel = 0, a_sel = 0;
  bit       m_fresh = 1;
  int       m_cnt = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkdiv_slice #(.NUM_SRC(8)) u_clkdiv_slice (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .out_pulse(out_pulse), .running(running));

  clkdiv_slice #(.NUM_SRC(4)) u_clkdiv_slice_four (
    .clk(clk), .rst_n(rst_n), .src_tick(tick4), .wr_en(wr_en4), .wr_data(wr_data),
    .rd_data(rd4), .out_pulse(out4), .running(run4));

  clkdiv_slice #(.NUM_SRC(1)) u_clkdiv_slice_one (
    .clk(clk), .rst_n(rst_n), .src_tick(tick1), .wr_en(wr_en1), .wr_data(wr_data),
    .rd_data(rd1), .out_pulse(out1), .running(run1));

  // model of one cycle of the main slice
  task automatic model_step(input bit [7:0] t, input bit we, input bit [31:0] d);
    bit [5:0] use_ratio = m_fresh ? m_ratio : a_ratio;
    bit [2:0] use_sel   = m_fresh ? m_sel   : a_sel;
    bit       hit       = !m_stop && t[use_sel];
    if (hit && m_cnt == use_ratio) begin
      exp_cyc.push_back(cyc);
      exp_tag.push_back(cur_tag);
    end
    if (m_stop) begin
      m_fresh = 1; m_cnt = 0;
    end else begin
      if (m_fresh) begin a_ratio = m_ratio; a_sel = m_sel; end
      m_fresh = 0;
      if (hit) begin
        if (m_cnt == use_ratio) begin m_cnt = 0; a_ratio = m_ratio; a_sel = m_sel; end
        else m_cnt++;
      end
    end
    if (we) begin
      m_stop  = d[8];
      m_ratio = (d[8] && d[5:0] == 0) ? 6'd63 : d[5:0];
      m_sel   = d[14:12];
    end
  endtask

  task automatic drive(input bit [7:0] t, input bit we, input bit [31:0] d,
                       input bit we4 = 0, input bit we1 = 0, input bit t1 = 0);
    @(posedge clk); #1;
    src_tick = t; wr_en = we; wr_data = d; wr_en4 = we4; wr_en1 = we1; tick1 = t1;
    model_step(t, we, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(8'h0, 0, 32'h0);
  endtask

  task automatic wr(input bit [31:0] d);
    drive(8'h0, 1, d);
  endtask

  task automatic ticks(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      drive(8'(1 << src), 0, 32'h0);
      drive(8'h0, 0, 32'h0);
    end
  endtask

  task automatic check(input bit [31:0] act, input bit [31:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_rd(input bit [31:0] exp, input string tag);
    idle(1);
    @(negedge clk);
    check(rd_data, exp, tag, "main readback");
  endtask

  task automatic drained(input string tag);
    idle(2);
    @(negedge clk);
    check(exp_cyc.size(), 0, tag, "pending expected pulses");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_pulse) begin
      checks++;
      if (exp_cyc.size() == 0) begin
        failures++;
        $display("FAIL %s unexpected pulse actual=cycle %0d expected=none", cur_tag, cyc);
      end else begin
        int    e;
        string t;
        e = exp_cyc.pop_front();
        t = exp_tag.pop_front();
        if (e != cyc) begin
          failures++;
          $display("FAIL %s pulse cycle actual=%0d expected=%0d", t, cyc, e);
        end
      end
    end
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    cur_tag = "R1";
    @(negedge clk);
    check(rd_data, 32'h0000_013F, "R1", "reset readback");
    check(running, 0, "R1", "reset running");
    ticks(0, 3);
    drained("R1");

    // R2 divide by 3, then by 1
    cur_tag = "R2";
    wr(32'h0000_0002);
    check_rd(32'h0000_0002, "R2");
    check(running, 1, "R3", "running after start");
    ticks(0, 9);
    drained("R2");
    wr(32'h0000_0000);
    for (int i = 0; i < 4; i++) drive(8'h01, 0, 0);
    drained("R2");

    // R7 unselected inputs ignored
    cur_tag = "R7";
    ticks(5, 4);
    ticks(1, 4);
    drained("R7");

    // R3 / R4 stop with partial count, zero ratio folds to 63
    cur_tag = "R3";
    wr(32'h0000_0003);
    ticks(0, 2);
    wr(32'h0000_0100);
    check_rd(32'h0000_013F, "R4");
    check(running, 0, "R3", "running while stopped");
    ticks(0, 5);
    drained("R3");
    wr(32'h0000_0105);
    check_rd(32'h0000_0105, "R4");

    // R5 restart at new ratio and source
    cur_tag = "R5";
    ticks(2, 2);
    wr(32'h0000_2004);
    check_rd(32'h0000_2004, "R7");
    ticks(2, 10);
    drained("R5");

    // R6 ratio change mid period
    cur_tag = "R6";
    ticks(2, 2);
    wr(32'h0000_2001);
    ticks(2, 3);
    ticks(2, 4);
    drained("R6");

    // R6 write in the same cycle as the completing strobe
    ticks(2, 1);
    drive(8'h04, 1, 32'h0000_2000);
    idle(1);
    ticks(2, 2);
    ticks(2, 3);
    drained("R6");

    // R7 select change only at a boundary
    cur_tag = "R7";
    wr(32'h0000_2002);
    ticks(2, 1);
    ticks(2, 1);
    wr(32'h0000_3002);
    ticks(3, 2);
    ticks(2, 2);
    ticks(3, 3);
    ticks(2, 3);
    drained("R7");

    // R9 undefined bits
    cur_tag = "R9";
    wr(32'hFFFF_FEC7);
    check_rd(32'h0000_7007, "R9");
    wr(32'hFFFF_FFC0);
    check_rd(32'h0000_713F, "R9");

    // four-source field position
    drive(8'h0, 0, 32'hFFFF_FFFF, 1, 0);
    idle(1); @(negedge clk);
    check(rd4, 32'h0000_01FF, "R7", "four-source readback");
    drive(8'h0, 0, 32'h0000_7080, 1, 0);
    idle(1); @(negedge clk);
    check(rd4, 32'h0000_0080, "R7", "four-source select bits");

    // single-source slice
    drive(8'h0, 0, 32'hFFFF_FFFF, 0, 1);
    idle(1); @(negedge clk);
    check(rd1, 32'h0000_013F, "R8", "single-source readback");
    drive(8'h0, 0, 32'h0000_70C0, 0, 1);
    idle(1); @(negedge clk);
    check(rd1, 32'h0000_0000, "R8", "single-source no select bits");
    drive(8'h0, 0, 32'h0, 0, 0, 1);
    @(negedge clk);
    check(out1, 1, "R8", "single-source pulse");
    idle(1);

    done = 1;
    summary();
    $finish;
  end

endmodule